// File: doc/BRIEF.md
# Cartridge 4 kB Program Bank Mapper

This block is the bank-switching logic of a game cartridge for an 8-bit CPU. It holds eight 8-bit bank numbers. It splits the CPU window $8000-$FFFF into eight 4 kB slots, and each slot shows whichever 4 kB page of a program ROM (up to 1 MB) its bank number selects. Software changes a slot with a single CPU write anywhere in $5000-$5FFF. The low three address bits of that write pick the slot, and the data byte is the new page number.

Two inputs initialise the block in different ways. A power-on reset (`por_ni`) loads the registers: the top slot gets page $FF, so the last ROM page is visible where the CPU fetches its vectors, and the other slots get page 0. The ordinary system reset (`rst_ni`) leaves every bank number as it is. While it is held low, it only blocks register writes.

The block also drives the picture-processor side. It passes the low 13 address bits through to an unbanked 8 kB pattern memory and derives that memory's chip enable. It also forms the nametable A10 line from a static input that selects horizontal or vertical mirroring.

Top module: `prg_bank_mapper`

## Requirements
- R1: While `por_ni` is low, slot 7 holds page $FF and slots 0-6 hold page $00; these values remain after `por_ni` rises.
- R2: On a rising clock edge with `cpu_wr_i`, `cpu_cyc_i` and `rst_ni` high and `cpu_addr_i[15:12]` = 4'b0101, the slot numbered `cpu_addr_i[2:0]` loads `cpu_data_i`; `cpu_addr_i[11:3]` does not affect which slot is written.
- R3: `prg_addr_o` = {bank of slot `cpu_addr_i[14:12]`, `cpu_addr_i[11:0]`}, combinationally, and it reflects a register write from the clock edge that performed it.
- R4: `prg_ce_o` is high exactly when `cpu_rd_i` is high and `cpu_addr_i[15]` is 1.
- R5: Writes whose `cpu_addr_i[15:12]` differs from 4'b0101 (including writes into the ROM window) leave every bank number unchanged.
- R6: A write with `cpu_wr_i` low or `cpu_cyc_i` low leaves every bank number unchanged.
- R7: While `rst_ni` is low, writes are ignored, and no bank number changes when `rst_ni` falls or rises.
- R8: `ciram_a10_o` equals `ppu_addr_i[10]` when `mirror_vert_i` is 1 (vertical) and `ppu_addr_i[11]` when it is 0 (horizontal).
- R9: `chr_addr_o` = `ppu_addr_i[12:0]`, and `chr_ce_o` is high exactly when `ppu_addr_i[13]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU-side clock |
| por_ni | input | 1 | Active-low asynchronous power-on reset; initialises the bank numbers |
| rst_ni | input | 1 | Active-low system reset; blocks writes and keeps the bank numbers |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_cyc_i | input | 1 | CPU cycle valid qualifier |
| mirror_vert_i | input | 1 | Static mirroring select: 1 vertical, 0 horizontal |
| ppu_addr_i | input | 14 | Picture-processor address |
| prg_addr_o | output | 20 | Program ROM address |
| prg_ce_o | output | 1 | Program ROM chip enable |
| chr_addr_o | output | 13 | Pattern memory address |
| chr_ce_o | output | 1 | Pattern memory chip select |
| ciram_a10_o | output | 1 | Nametable A10 |

## Verification
The assertions expect `mirror_vert_i` to be static and CPU inputs to be stable around the sampling clock edge. They judge register writes only from the decoded port conditions. The bench changes every input on the falling edge and holds it through the next rising edge. It toggles the mirroring select only while no picture-processor check is pending, and it releases `por_ni` away from any clock edge.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int unsigned CPU_AW  = 16;
  localparam int unsigned PPU_AW  = 14;
  localparam int unsigned BANK_W  = 8;
  localparam int unsigned PAGE_W  = 12;
  localparam int unsigned SLOT_N  = 8;
  localparam int unsigned SLOT_W  = $clog2(SLOT_N);
  localparam logic [3:0]  REG_NIB = 4'h5;

  typedef enum logic {
    MIR_HORIZ = 1'b0,
    MIR_VERT  = 1'b1
  } mirror_e;
endpackage

// File: rtl/bank_wr_decode.sv
module bank_wr_decode
  import mapper_pkg::*;
#(
  parameter int unsigned SLOT_N_P = SLOT_N,
  localparam int unsigned SW = $clog2(SLOT_N_P)
) (
  input  logic          rst_ni,
  input  logic [3:0]    addr_hi_i,
  input  logic [SW-1:0] addr_lo_i,
  input  logic          wr_i,
  input  logic          cyc_i,
  output logic [SLOT_N_P-1:0] load_o
);
  logic hit;

  assign hit = wr_i & cyc_i & rst_ni & (addr_hi_i == REG_NIB);

  for (genvar s = 0; s < SLOT_N_P; s++) begin : g_sel
    assign load_o[s] = hit & (addr_lo_i == SW'(s));
  end
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import mapper_pkg::*;
#(
  parameter int unsigned SLOT_N_P = SLOT_N,
  parameter int unsigned BANK_W_P = BANK_W
) (
  input  logic                         clk_i,
  input  logic                         por_ni,
  input  logic [SLOT_N_P-1:0]          load_i,
  input  logic [BANK_W_P-1:0]          data_i,
  output logic [SLOT_N_P*BANK_W_P-1:0] bank_o
);
  for (genvar s = 0; s < SLOT_N_P; s++) begin : g_slot
    // only the top slot boots to the last page
    localparam logic [BANK_W_P-1:0] INIT = (s == SLOT_N_P - 1) ? '1 : '0;
    logic [BANK_W_P-1:0] q;

    always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni)        q <= INIT;
      else if (load_i[s]) q <= data_i;
    end

    assign bank_o[s*BANK_W_P +: BANK_W_P] = q;
  end
endmodule

// File: rtl/prg_addr_map.sv
module prg_addr_map
  import mapper_pkg::*;
#(
  parameter int unsigned SLOT_N_P = SLOT_N,
  parameter int unsigned BANK_W_P = BANK_W,
  parameter int unsigned PAGE_W_P = PAGE_W,
  localparam int unsigned SW = $clog2(SLOT_N_P)
) (
  input  logic [PAGE_W_P+SW:0]          cpu_addr_i,
  input  logic                          rd_i,
  input  logic [SLOT_N_P*BANK_W_P-1:0]  bank_i,
  output logic [BANK_W_P+PAGE_W_P-1:0]  prg_addr_o,
  output logic                          prg_ce_o
);
  logic [SW-1:0]       slot;
  logic [BANK_W_P-1:0] page;

  assign slot       = cpu_addr_i[PAGE_W_P +: SW];
  assign page       = bank_i[int'(slot)*BANK_W_P +: BANK_W_P];
  assign prg_addr_o = {page, cpu_addr_i[PAGE_W_P-1:0]};
  assign prg_ce_o   = rd_i & cpu_addr_i[PAGE_W_P+SW];
endmodule

// File: rtl/ppu_map.sv
module ppu_map
  import mapper_pkg::*;
#(
  parameter int unsigned PPU_AW_P = PPU_AW
) (
  input  logic [PPU_AW_P-1:0] ppu_addr_i,
  input  logic                mirror_vert_i,
  output logic [PPU_AW_P-2:0] chr_addr_o,
  output logic                chr_ce_o,
  output logic                ciram_a10_o
);
  mirror_e mode;

  assign mode       = mirror_e'(mirror_vert_i);
  assign chr_addr_o = ppu_addr_i[PPU_AW_P-2:0];
  assign chr_ce_o   = ~ppu_addr_i[PPU_AW_P-1];

  always_comb begin
    unique case (mode)
      MIR_VERT:  ciram_a10_o = ppu_addr_i[10];
      default:   ciram_a10_o = ppu_addr_i[11];
    endcase
  end
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import mapper_pkg::*;
#(
  parameter int unsigned SLOT_N_P = SLOT_N,
  parameter int unsigned BANK_W_P = BANK_W,
  localparam int unsigned SW   = $clog2(SLOT_N_P),
  localparam int unsigned PA_W = BANK_W_P + PAGE_W
) (
  input  logic                  clk_i,
  input  logic                  por_ni,
  input  logic                  rst_ni,
  input  logic [CPU_AW-1:0]     cpu_addr_i,
  input  logic [BANK_W_P-1:0]   cpu_data_i,
  input  logic                  cpu_wr_i,
  input  logic                  cpu_rd_i,
  input  logic                  cpu_cyc_i,
  input  logic                  mirror_vert_i,
  input  logic [PPU_AW-1:0]     ppu_addr_i,
  output logic [PA_W-1:0]       prg_addr_o,
  output logic                  prg_ce_o,
  output logic [PPU_AW-2:0]     chr_addr_o,
  output logic                  chr_ce_o,
  output logic                  ciram_a10_o
);
  logic [SLOT_N_P-1:0]          load;
  logic [SLOT_N_P*BANK_W_P-1:0] bank_flat;

  bank_wr_decode #(.SLOT_N_P(SLOT_N_P)) u_dec (
    .rst_ni    (rst_ni),
    .addr_hi_i (cpu_addr_i[CPU_AW-1 -: 4]),
    .addr_lo_i (cpu_addr_i[SW-1:0]),
    .wr_i      (cpu_wr_i),
    .cyc_i     (cpu_cyc_i),
    .load_o    (load)
  );

  bank_regfile #(.SLOT_N_P(SLOT_N_P), .BANK_W_P(BANK_W_P)) u_regs (
    .clk_i  (clk_i),
    .por_ni (por_ni),
    .load_i (load),
    .data_i (cpu_data_i),
    .bank_o (bank_flat)
  );

  prg_addr_map #(.SLOT_N_P(SLOT_N_P), .BANK_W_P(BANK_W_P), .PAGE_W_P(PAGE_W)) u_prg (
    .cpu_addr_i (cpu_addr_i[PAGE_W+SW:0]),
    .rd_i       (cpu_rd_i),
    .bank_i     (bank_flat),
    .prg_addr_o (prg_addr_o),
    .prg_ce_o   (prg_ce_o)
  );

  ppu_map #(.PPU_AW_P(PPU_AW)) u_ppu (
    .ppu_addr_i    (ppu_addr_i),
    .mirror_vert_i (mirror_vert_i),
    .chr_addr_o    (chr_addr_o),
    .chr_ce_o      (chr_ce_o),
    .ciram_a10_o   (ciram_a10_o)
  );
endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk
  import mapper_pkg::*;
(
  input logic                     clk_i,
  input logic                     por_ni,
  input logic                     rst_ni,
  input logic [CPU_AW-1:0]        cpu_addr_i,
  input logic [BANK_W-1:0]        cpu_data_i,
  input logic                     cpu_wr_i,
  input logic                     cpu_rd_i,
  input logic                     cpu_cyc_i,
  input logic                     mirror_vert_i,
  input logic [PPU_AW-1:0]        ppu_addr_i,
  input logic [BANK_W+PAGE_W-1:0] prg_addr_o,
  input logic                     prg_ce_o,
  input logic [PPU_AW-2:0]        chr_addr_o,
  input logic                     chr_ce_o,
  input logic                     ciram_a10_o,
  input logic [SLOT_N*BANK_W-1:0] bank_flat
);
  logic reg_wr;
  assign reg_wr = cpu_wr_i && cpu_cyc_i && rst_ni && cpu_addr_i[15:12] == 4'b0101;

  assert_por_top_R1: assert property (@(posedge clk_i)
    $rose(por_ni) |-> bank_flat[SLOT_N*BANK_W-1 -: BANK_W] == 8'hFF);

  assert_reg_load_R2: assert property (@(posedge clk_i) disable iff (!por_ni)
    $past(reg_wr) |-> bank_flat[int'($past(cpu_addr_i[2:0]))*BANK_W +: BANK_W] == $past(cpu_data_i));

  assert_page_offset_R3: assert property (@(posedge clk_i) disable iff (!por_ni)
    prg_addr_o[PAGE_W-1:0] == cpu_addr_i[PAGE_W-1:0]);

  assert_page_sel_R3: assert property (@(posedge clk_i) disable iff (!por_ni)
    prg_addr_o[PAGE_W +: BANK_W] == bank_flat[int'(cpu_addr_i[14:12])*BANK_W +: BANK_W]);

  assert_rom_ce_R4: assert property (@(posedge clk_i) disable iff (!por_ni)
    prg_ce_o == (cpu_rd_i && cpu_addr_i[15]));

  // covers R5, R6 and R7: no qualified write, no change
  assert_bank_hold_R5: assert property (@(posedge clk_i) disable iff (!por_ni)
    !$past(reg_wr) |-> $stable(bank_flat));

  assert_rst_hold_R7: assert property (@(posedge clk_i) disable iff (!por_ni)
    !$past(rst_ni) |-> $stable(bank_flat));

  assert_mirror_R8: assert property (@(posedge clk_i) disable iff (!por_ni)
    ciram_a10_o == (mirror_vert_i ? ppu_addr_i[10] : ppu_addr_i[11]));

  assert_chr_R9: assert property (@(posedge clk_i) disable iff (!por_ni)
    chr_ce_o == !ppu_addr_i[13] && chr_addr_o == ppu_addr_i[12:0]);
endmodule

bind prg_bank_mapper prg_bank_mapper_chk u_chk (
  .clk_i         (clk_i),
  .por_ni        (por_ni),
  .rst_ni        (rst_ni),
  .cpu_addr_i    (cpu_addr_i),
  .cpu_data_i    (cpu_data_i),
  .cpu_wr_i      (cpu_wr_i),
  .cpu_rd_i      (cpu_rd_i),
  .cpu_cyc_i     (cpu_cyc_i),
  .mirror_vert_i (mirror_vert_i),
  .ppu_addr_i    (ppu_addr_i),
  .prg_addr_o    (prg_addr_o),
  .prg_ce_o      (prg_ce_o),
  .chr_addr_o    (chr_addr_o),
  .chr_ce_o      (chr_ce_o),
  .ciram_a10_o   (ciram_a10_o),
  .bank_flat     (bank_flat)
);

// File: tb/prg_bank_mapper_test.sv
module prg_bank_mapper_test;
  logic        clk_i = 1'b0;
  logic        por_ni = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic [7:0]  cpu_data_i = '0;
  logic        cpu_wr_i = 1'b0;
  logic        cpu_rd_i = 1'b0;
  logic        cpu_cyc_i = 1'b0;
  logic        mirror_vert_i = 1'b0;
  logic [13:0] ppu_addr_i = '0;
  logic [19:0] prg_addr_o;
  logic        prg_ce_o;
  logic [12:0] chr_addr_o;
  logic        chr_ce_o;
  logic        ciram_a10_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [8];

  always #10 clk_i = ~clk_i;

  prg_bank_mapper uut (
    .clk_i, .por_ni, .rst_ni, .cpu_addr_i, .cpu_data_i, .cpu_wr_i, .cpu_rd_i,
    .cpu_cyc_i, .mirror_vert_i, .ppu_addr_i, .prg_addr_o, .prg_ce_o,
    .chr_addr_o, .chr_ce_o, .ciram_a10_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_write(logic [15:0] a, logic [7:0] d, logic wr, logic cyc);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_data_i = d; cpu_wr_i = wr; cpu_cyc_i = cyc; cpu_rd_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    cpu_wr_i = 1'b0; cpu_cyc_i = 1'b0;
  endtask

  task automatic read_slot(int s, logic [11:0] off, string req);
    @(negedge clk_i);
    cpu_addr_i = 16'h8000 | 16'(s << 12) | 16'(off); cpu_rd_i = 1'b1; cpu_cyc_i = 1'b1;
    #5;
    check(req, 32'(prg_addr_o), 32'({model[s], off}));
    check(req, 32'(prg_ce_o), 32'd1);
    cpu_rd_i = 1'b0; cpu_cyc_i = 1'b0;
  endtask

  task automatic check_all(string req);
    for (int s = 0; s < 8; s++) read_slot(s, 12'(s * 12'h155 + 3), req);
  endtask

  task automatic model_por();
    for (int s = 0; s < 8; s++) model[s] = (s == 7) ? 8'hFF : 8'h00;
  endtask

  task automatic t_power_on();
    por_ni = 1'b0;
    model_por();
    #3;
    check("R1 slot7 during por", 32'(uut.prg_addr_o >> 12), 32'(model[cpu_addr_i[14:12]]));
    @(negedge clk_i); #7; por_ni = 1'b1;
    check_all("R1");
  endtask

  task automatic t_write_all();
    for (int s = 0; s < 8; s++) begin
      model[s] = 8'(8'h10 + s * 37);
      cpu_write(16'h5FF8 + 16'(s), model[s], 1'b1, 1'b1);
    end
    check_all("R2/R3 canonical writes");
    for (int s = 0; s < 8; s++) begin
      model[s] = 8'(8'hC3 ^ (s * 17));
      cpu_write(16'h5000 | 16'((s * 8'h2D) << 3) | 16'(s), model[s], 1'b1, 1'b1);
    end
    check_all("R2 bits 11:3 ignored");
    // written value visible right after the write edge
    cpu_write(16'h5A33, 8'h5E, 1'b1, 1'b1);
    model[3] = 8'h5E;
    read_slot(3, 12'hFFF, "R3 immediate");
  endtask

  task automatic t_decode_miss();
    cpu_write(16'h4FF8, 8'hAA, 1'b1, 1'b1);
    cpu_write(16'h6FFF, 8'hAA, 1'b1, 1'b1);
    cpu_write(16'hDFF9, 8'hAA, 1'b1, 1'b1);
    cpu_write(16'h8FFA, 8'hAA, 1'b1, 1'b1);
    cpu_write(16'h0FFB, 8'hAA, 1'b1, 1'b1);
    check_all("R5");
  endtask

  task automatic t_qualifiers();
    cpu_write(16'h5FF9, 8'h77, 1'b1, 1'b0);
    cpu_write(16'h5FFA, 8'h77, 1'b0, 1'b1);
    cpu_write(16'h5FFF, 8'h77, 1'b0, 1'b0);
    check_all("R6");
  endtask

  task automatic t_reset_hold();
    @(negedge clk_i); rst_ni = 1'b0;
    cpu_write(16'h5FFC, 8'h99, 1'b1, 1'b1);
    cpu_write(16'h5FFF, 8'h99, 1'b1, 1'b1);
    @(negedge clk_i); rst_ni = 1'b1;
    check_all("R7");
    model[7] = 8'h42;
    cpu_write(16'h5FFF, 8'h42, 1'b1, 1'b1);
    read_slot(7, 12'hFFC, "R7 writes resume");
  endtask

  task automatic t_rom_ce();
    logic [15:0] a [4] = '{16'h8000, 16'h7FFF, 16'hFFFF, 16'h5FF8};
    for (int i = 0; i < 4; i++) begin
      for (int r = 0; r < 2; r++) begin
        @(negedge clk_i);
        cpu_addr_i = a[i]; cpu_rd_i = r[0];
        #5;
        check("R4", 32'(prg_ce_o), 32'(r[0] & a[i][15]));
      end
    end
    cpu_rd_i = 1'b0;
  endtask

  task automatic t_mirror();
    logic [13:0] p [4] = '{14'h2000, 14'h2400, 14'h2800, 14'h2C00};
    for (int m = 0; m < 2; m++) begin
      @(negedge clk_i); mirror_vert_i = m[0];
      for (int i = 0; i < 4; i++) begin
        @(negedge clk_i); ppu_addr_i = p[i] | 14'h1A5; #5;
        check(m[0] ? "R8 vertical" : "R8 horizontal", 32'(ciram_a10_o),
              32'(m[0] ? p[i][10] : p[i][11]));
      end
    end
  endtask

  task automatic t_chr();
    logic [13:0] p [4] = '{14'h0000, 14'h1ABC, 14'h1FFF, 14'h2ABC};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i); ppu_addr_i = p[i]; #5;
      check("R9 addr", 32'(chr_addr_o), 32'(p[i][12:0]));
      check("R9 ce", 32'(chr_ce_o), 32'(!p[i][13]));
    end
  endtask

  initial begin : watchdog
    #(20 * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_power_on();
    t_write_all();
    t_decode_miss();
    t_qualifiers();
    t_reset_hold();
    t_rom_ce();
    t_mirror();
    t_chr();
    t_power_on();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule